// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register store of a 32-bit processor core that has seven operating modes. Sixteen register names, r0 to r15, are visible to the datapath at any time, but the physical storage behind some of those names changes with the operating mode. An exception mode therefore has its own stack pointer and link register, and the fast-interrupt mode has its own upper half of the register set. Switching modes never requires copying registers. In total the block holds 31 general-purpose 32-bit registers and 6 status registers.

The datapath uses two registered read ports, one write port, and a separate program-counter write port. Reading r15 does not return the stored program counter. It returns the counter plus a fixed pipeline offset that depends on the instruction state. The current status word holds the mode code and the state bit, and it is loaded through its own port. A saved status word exists for each exception mode. Its port always refers to the saved word of the mode that is currently selected.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous reset sets the current status word to 0x00000013, which is mode code 10011 (Supervisor) in bits [4:0] with the state bit clear, and sets the stored program counter `pc_q` to zero.
- R2: A read port returns the content of the register named by its index one clock edge after the index is presented. A write made through `wr_en` is visible to every later read in the same mode.
- R3: Bits [4:0] of the current status word select the mode. In FIQ mode (10001), r8 to r14 use private storage. IRQ (10010), Supervisor (10011), Abort (10111) and Undefined (11011) each have private r13 and r14. Every other name in these modes reaches the User copy.
- R4: System mode (11111) and any unlisted mode code use the User registers.
- R5: A write and a read of the same register name in the same cycle deliver the newly written value on the read port (write-first).
- R6: Reading r15 returns the program counter plus 8 when state bit 5 of the current status word is 0 (32-bit state), and plus 4 when it is 1 (16-bit state).
- R7: A program-counter write, whether through `pc_we` or through the write port with index 15, clears bits [1:0] in the 32-bit state and clears bit 0 in the 16-bit state.
- R8: When `pc_we` and a write-port write to r15 occur in the same cycle, the value from `pc_wdata` is the one stored.
- R9: A write through `cpsr_we` loads `cpsr_wdata` into the current status word at the next edge. The mode and state take effect from that edge.
- R10: FIQ, IRQ, Supervisor, Abort and Undefined each own one saved status word. `spsr_q` shows the word of the current mode, and `spsr_we` writes only that word.
- R11: In User mode, System mode and unlisted mode codes, `spsr_q` reads zero and `spsr_we` changes no saved status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Read port A register name |
| rd_a_data | output | 32 | Read port A data, one edge after the index |
| rd_b_idx | input | 4 | Read port B register name |
| rd_b_data | output | 32 | Read port B data, one edge after the index |
| wr_en | input | 1 | Write port enable |
| wr_idx | input | 4 | Write port register name |
| wr_data | input | 32 | Write port data |
| pc_we | input | 1 | Dedicated program-counter write enable |
| pc_wdata | input | 32 | Dedicated program-counter write data |
| pc_q | output | 32 | Stored program counter |
| cpsr_we | input | 1 | Current status word write enable |
| cpsr_wdata | input | 32 | Current status word write data |
| cpsr_q | output | 32 | Current status word |
| spsr_we | input | 1 | Saved status word write enable (current mode) |
| spsr_wdata | input | 32 | Saved status word write data |
| spsr_q | output | 32 | Saved status word of the current mode |

## Verification
The read data, including the r15 value with its offset, is due on the first rising edge after the index is driven. `pc_q`, `cpsr_q` and `spsr_q` take a written value at the first rising edge after the write. `spsr_q` also follows a mode change at the edge that loads the new status word. The bench drives every input at a falling edge and samples at the next falling edge, so exactly one rising edge lies between a stimulus and its check. Each mode switch is followed by a separate cycle before the next access, so every access runs in a settled mode.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  // Bank selected by the mode code
  typedef enum logic [2:0] {
    BK_USR, BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND, BK_SYS
  } bank_e;

  localparam logic [4:0] MC_USR = 5'b10000;
  localparam logic [4:0] MC_FIQ = 5'b10001;
  localparam logic [4:0] MC_IRQ = 5'b10010;
  localparam logic [4:0] MC_SVC = 5'b10011;
  localparam logic [4:0] MC_ABT = 5'b10111;
  localparam logic [4:0] MC_UND = 5'b11011;
  localparam logic [4:0] MC_SYS = 5'b11111;

  localparam int GPR_DEPTH = 30;          // r15 lives outside the array
  localparam int GPR_AW    = $clog2(GPR_DEPTH);
  localparam int SPSR_N    = 5;
  localparam int SLOT_W    = $clog2(SPSR_N);

  function automatic bank_e decode_mode(input logic [4:0] code);
    case (code)
      MC_FIQ:  return BK_FIQ;
      MC_IRQ:  return BK_IRQ;
      MC_SVC:  return BK_SVC;
      MC_ABT:  return BK_ABT;
      MC_UND:  return BK_UND;
      MC_SYS:  return BK_SYS;
      default: return BK_USR;
    endcase
  endfunction

  function automatic logic has_spsr(input bank_e b);
    return (b == BK_FIQ) || (b == BK_IRQ) || (b == BK_SVC) ||
           (b == BK_ABT) || (b == BK_UND);
  endfunction

  function automatic logic [SLOT_W-1:0] spsr_slot(input bank_e b);
    case (b)
      BK_IRQ:  return SLOT_W'(1);
      BK_SVC:  return SLOT_W'(2);
      BK_ABT:  return SLOT_W'(3);
      BK_UND:  return SLOT_W'(4);
      default: return SLOT_W'(0);
    endcase
  endfunction

  // Layout: 0..14 shared, 15..21 FIQ r8..r14, then pairs for IRQ/SVC/ABT/UND
  function automatic logic [GPR_AW-1:0] phys_of(input bank_e b, input logic [3:0] r);
    logic [GPR_AW-1:0] base;
    logic              hi;
    hi   = (r == 4'd14);
    base = GPR_AW'(0);
    case (b)
      BK_IRQ:  base = GPR_AW'(22);
      BK_SVC:  base = GPR_AW'(24);
      BK_ABT:  base = GPR_AW'(26);
      BK_UND:  base = GPR_AW'(28);
      default: base = GPR_AW'(0);
    endcase
    if (b == BK_FIQ && r >= 4'd8 && r <= 4'd14)
      return GPR_AW'(r) + GPR_AW'(7);
    else if ((r == 4'd13 || r == 4'd14) && base != GPR_AW'(0))
      return base + GPR_AW'(hi);
    else
      return GPR_AW'(r);
  endfunction

endpackage

// File: rtl/bank_map.sv
module bank_map
  import regbank_pkg::*;
#(
  parameter int AW = GPR_AW
) (
  input  bank_e         bank,
  input  logic [3:0]    arch_idx,
  output logic [AW-1:0] phys_idx
);
  assign phys_idx = AW'(phys_of(bank, arch_idx));
endmodule

// File: rtl/gpr_store.sv
module gpr_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 30,
  parameter int NUM_RD = 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                           clk,
  input  logic                           we,
  input  logic [AW-1:0]                  waddr,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [NUM_RD-1:0][AW-1:0]      raddr,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    always_ff @(posedge clk) begin
      rdata[p] <= mem[raddr[p]];
    end
  end
endmodule

// File: rtl/pc_unit.sv
module pc_unit #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              thumb,
  input  logic              pc_we,
  input  logic [DATA_W-1:0] pc_wdata,
  input  logic              gp_we,
  input  logic [DATA_W-1:0] gp_wdata,
  output logic [DATA_W-1:0] pc_q,
  output logic [DATA_W-1:0] pc_read
);
  logic [DATA_W-1:0] src, mask, pc_d;

  assign src  = pc_we ? pc_wdata : gp_wdata;
  assign mask = {{(DATA_W-2){1'b1}}, thumb, 1'b0};
  assign pc_d = (pc_we || gp_we) ? (src & mask) : pc_q;
  // r15 read reflects a same-cycle write plus the pipeline offset
  assign pc_read = pc_d + (thumb ? DATA_W'(4) : DATA_W'(8));

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_d;
  end

  // R7
  pc_even_chk: assert property (@(posedge clk) disable iff (rst)
    pc_q[0] == 1'b0);

  // R7
  pc_word_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_we && !thumb) |=> pc_q[1:0] == 2'b00);

  // R8
  pc_port_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (pc_we && gp_we) |=> pc_q[DATA_W-1:2] == $past(pc_wdata[DATA_W-1:2]));
endmodule

// File: rtl/status_bank.sv
module status_bank
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NSPSR  = SPSR_N
) (
  input  logic              clk,
  input  logic              rst,
  input  bank_e             bank,
  input  logic              cpsr_we,
  input  logic [DATA_W-1:0] cpsr_wdata,
  output logic [DATA_W-1:0] cpsr_q,
  input  logic              spsr_we,
  input  logic [DATA_W-1:0] spsr_wdata,
  output logic [DATA_W-1:0] spsr_q
);
  localparam logic [DATA_W-1:0] CPSR_RST = DATA_W'(MC_SVC);

  logic [NSPSR-1:0][DATA_W-1:0] spsr_r;
  logic [NSPSR-1:0]             slot_we;
  logic                         owns;
  logic [SLOT_W-1:0]            slot;

  assign owns = has_spsr(bank);
  assign slot = spsr_slot(bank);

  always_ff @(posedge clk) begin
    if (rst)          cpsr_q <= CPSR_RST;
    else if (cpsr_we) cpsr_q <= cpsr_wdata;
  end

  for (genvar g = 0; g < NSPSR; g++) begin : g_spsr
    assign slot_we[g] = spsr_we && owns && (slot == SLOT_W'(g));
    always_ff @(posedge clk) begin
      if (slot_we[g]) spsr_r[g] <= spsr_wdata;
    end
  end

  assign spsr_q = owns ? spsr_r[slot] : '0;

  // R9
  cpsr_load_chk: assert property (@(posedge clk) disable iff (rst)
    cpsr_we |=> cpsr_q == $past(cpsr_wdata));

  // R10
  spsr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slot_we));

  // R11
  spsr_user_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bank == BK_USR || bank == BK_SYS) |-> spsr_q == '0);

  // R11
  spsr_user_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (spsr_we && (bank == BK_USR || bank == BK_SYS)) |=> $stable(spsr_r));
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_RD = 2,
  localparam int AW    = GPR_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pc_we,
  input  logic [DATA_W-1:0] pc_wdata,
  output logic [DATA_W-1:0] pc_q,
  input  logic              cpsr_we,
  input  logic [DATA_W-1:0] cpsr_wdata,
  output logic [DATA_W-1:0] cpsr_q,
  input  logic              spsr_we,
  input  logic [DATA_W-1:0] spsr_wdata,
  output logic [DATA_W-1:0] spsr_q
);
  localparam logic [3:0] PC_IDX = 4'd15;

  bank_e                          cur_bank;
  logic                           thumb;
  logic                           gpr_we, pcw_gp;
  logic [AW-1:0]                  w_phys;
  logic [NUM_RD-1:0][3:0]         r_arch;
  logic [NUM_RD-1:0][AW-1:0]      r_phys;
  logic [NUM_RD-1:0][DATA_W-1:0]  mem_q, rd_out;
  logic [NUM_RD-1:0]              byp_q, pcsel_q;
  logic [DATA_W-1:0]              byp_val_q, pc_read, pc_read_q;

  assign cur_bank = decode_mode(cpsr_q[4:0]);
  assign thumb    = cpsr_q[5];
  assign gpr_we   = wr_en && (wr_idx != PC_IDX);
  assign pcw_gp   = wr_en && (wr_idx == PC_IDX);

  assign r_arch[0] = rd_a_idx;
  assign r_arch[1] = rd_b_idx;

  status_bank #(.DATA_W(DATA_W)) i_status (
    .clk(clk), .rst(rst), .bank(cur_bank),
    .cpsr_we(cpsr_we), .cpsr_wdata(cpsr_wdata), .cpsr_q(cpsr_q),
    .spsr_we(spsr_we), .spsr_wdata(spsr_wdata), .spsr_q(spsr_q)
  );

  pc_unit #(.DATA_W(DATA_W)) i_pc (
    .clk(clk), .rst(rst), .thumb(thumb),
    .pc_we(pc_we), .pc_wdata(pc_wdata),
    .gp_we(pcw_gp), .gp_wdata(wr_data),
    .pc_q(pc_q), .pc_read(pc_read)
  );

  bank_map #(.AW(AW)) i_wmap (
    .bank(cur_bank), .arch_idx(wr_idx), .phys_idx(w_phys)
  );

  gpr_store #(.DATA_W(DATA_W), .DEPTH(GPR_DEPTH), .NUM_RD(NUM_RD)) i_store (
    .clk(clk), .we(gpr_we), .waddr(w_phys), .wdata(wr_data),
    .raddr(r_phys), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    byp_val_q <= wr_data;
    pc_read_q <= pc_read;
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_port
    bank_map #(.AW(AW)) i_rmap (
      .bank(cur_bank), .arch_idx(r_arch[p]), .phys_idx(r_phys[p])
    );
    always_ff @(posedge clk) begin
      pcsel_q[p] <= (r_arch[p] == PC_IDX);
      byp_q[p]   <= gpr_we && (wr_idx == r_arch[p]);
    end
    assign rd_out[p] = pcsel_q[p] ? pc_read_q :
                       byp_q[p]   ? byp_val_q : mem_q[p];
  end

  assign rd_a_data = rd_out[0];
  assign rd_b_data = rd_out[1];

  // R5
  rd_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == rd_a_idx && wr_idx != PC_IDX) |=> rd_a_data == $past(wr_data));

  // R6
  r15_offset_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_b_idx == PC_IDX && !pc_we && !pcw_gp && !cpsr_we)
      |=> rd_b_data == pc_q + (cpsr_q[5] ? DATA_W'(4) : DATA_W'(8)));
endmodule

// File: tb/test_banked_regfile.sv
`timescale 1ns/1ps
module test_banked_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, pc_wdata = '0, pc_q;
  logic [31:0] cpsr_wdata = '0, cpsr_q, spsr_wdata = '0, spsr_q;
  logic        wr_en = 1'b0, pc_we = 1'b0, cpsr_we = 1'b0, spsr_we = 1'b0;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  banked_regfile i_banked_regfile (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pc_we(pc_we), .pc_wdata(pc_wdata), .pc_q(pc_q),
    .cpsr_we(cpsr_we), .cpsr_wdata(cpsr_wdata), .cpsr_q(cpsr_q),
    .spsr_we(spsr_we), .spsr_wdata(spsr_wdata), .spsr_q(spsr_q)
  );

  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                         SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                         SYS = 5'b11111, BAD = 5'b00000;
  localparam logic OP_W = 1'b1, OP_R = 1'b0;
  // {op, mode, idx, value}: writes store value, reads expect it
  localparam int NV = 23;
  localparam logic [41:0] VEC [NV] = '{
    {OP_W, USR, 4'd8,  32'h1000_0008}, {OP_W, USR, 4'd13, 32'h1000_000D},
    {OP_W, USR, 4'd14, 32'h1000_000E}, {OP_W, USR, 4'd0,  32'h1000_0000},
    {OP_W, FIQ, 4'd8,  32'h2000_0008}, {OP_W, FIQ, 4'd13, 32'h2000_000D},
    {OP_W, IRQ, 4'd13, 32'h3000_000D}, {OP_W, SVC, 4'd13, 32'h4000_000D},
    {OP_W, ABT, 4'd14, 32'h5000_000E}, {OP_W, UND, 4'd14, 32'h6000_000E},
    {OP_W, SYS, 4'd0,  32'h7000_0000},
    {OP_R, USR, 4'd8,  32'h1000_0008}, {OP_R, FIQ, 4'd8,  32'h2000_0008},
    {OP_R, FIQ, 4'd0,  32'h7000_0000}, {OP_R, IRQ, 4'd13, 32'h3000_000D},
    {OP_R, IRQ, 4'd8,  32'h1000_0008}, {OP_R, SVC, 4'd13, 32'h4000_000D},
    {OP_R, SYS, 4'd13, 32'h1000_000D}, {OP_R, ABT, 4'd14, 32'h5000_000E},
    {OP_R, UND, 4'd14, 32'h6000_000E}, {OP_R, BAD, 4'd14, 32'h1000_000E},
    {OP_R, FIQ, 4'd13, 32'h2000_000D}, {OP_R, USR, 4'd0,  32'h7000_0000}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic set_mode(input logic [4:0] m, input logic t);
    @(negedge clk);
    cpsr_we = 1'b1; cpsr_wdata = {26'd0, t, m};
    @(negedge clk);
    cpsr_we = 1'b0;
    check("R9 status load", cpsr_q, {26'd0, t, m});
  endtask

  task automatic gp_write(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic gp_read(input string req, input logic [3:0] idx, input logic [31:0] exp);
    @(negedge clk);
    rd_a_idx = idx; rd_b_idx = idx;
    @(negedge clk);
    check({req, " port A"}, rd_a_data, exp);
    check({req, " port B"}, rd_b_data, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset status", cpsr_q, 32'h0000_0013);
    check("R1 reset pc", pc_q, 32'h0);

    // R2 R3 R4: banking table
    for (int i = 0; i < NV; i++) begin
      set_mode(VEC[i][40:36], 1'b0);
      if (VEC[i][41] == OP_W) gp_write(VEC[i][35:32], VEC[i][31:0]);
      else gp_read("R2 R3 R4 banked read", VEC[i][35:32], VEC[i][31:0]);
    end

    // R5: write-first on both ports
    set_mode(USR, 1'b0);
    gp_write(4'd3, 32'h1111_1111);
    gp_read("R2 plain read", 4'd3, 32'h1111_1111);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'h2222_2222;
    rd_a_idx = 4'd3; rd_b_idx = 4'd3;
    @(negedge clk);
    wr_en = 1'b0;
    check("R5 bypass A", rd_a_data, 32'h2222_2222);
    check("R5 bypass B", rd_b_data, 32'h2222_2222);

    // R6 R7 R8: program counter
    @(negedge clk); pc_we = 1'b1; pc_wdata = 32'h0000_0100;
    @(negedge clk); pc_we = 1'b0;
    check("R7 pc aligned", pc_q, 32'h0000_0100);
    gp_read("R6 r15 32-bit", 4'd15, 32'h0000_0108);
    @(negedge clk); pc_we = 1'b1; pc_wdata = 32'h0000_0203;
    @(negedge clk); pc_we = 1'b0;
    check("R7 pc word align", pc_q, 32'h0000_0200);
    set_mode(USR, 1'b1);
    gp_read("R6 r15 16-bit", 4'd15, 32'h0000_0204);
    gp_write(4'd15, 32'h0000_0207);
    check("R7 pc half align", pc_q, 32'h0000_0206);
    set_mode(USR, 1'b0);
    @(negedge clk);
    pc_we = 1'b1; pc_wdata = 32'h0000_0400;
    wr_en = 1'b1; wr_idx = 4'd15; wr_data = 32'h0000_0800;
    @(negedge clk);
    pc_we = 1'b0; wr_en = 1'b0;
    check("R8 pc port wins", pc_q, 32'h0000_0400);

    // R10 R11: saved status words
    set_mode(IRQ, 1'b0);
    @(negedge clk); spsr_we = 1'b1; spsr_wdata = 32'hAAAA_0012;
    @(negedge clk); spsr_we = 1'b0;
    check("R10 irq saved", spsr_q, 32'hAAAA_0012);
    set_mode(SVC, 1'b0);
    @(negedge clk); spsr_we = 1'b1; spsr_wdata = 32'hBBBB_0013;
    @(negedge clk); spsr_we = 1'b0;
    check("R10 svc saved", spsr_q, 32'hBBBB_0013);
    set_mode(IRQ, 1'b0);
    check("R10 irq kept", spsr_q, 32'hAAAA_0012);
    set_mode(USR, 1'b0);
    check("R11 user reads zero", spsr_q, 32'h0);
    @(negedge clk); spsr_we = 1'b1; spsr_wdata = 32'hDEAD_BEEF;
    @(negedge clk); spsr_we = 1'b0;
    check("R11 user write ignored", spsr_q, 32'h0);
    set_mode(SYS, 1'b0);
    check("R11 system reads zero", spsr_q, 32'h0);
    set_mode(IRQ, 1'b0);
    check("R11 irq untouched", spsr_q, 32'hAAAA_0012);
    set_mode(SVC, 1'b0);
    check("R11 svc untouched", spsr_q, 32'hBBBB_0013);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule